// File: doc/BRIEF.md
# Infrared Run-Length Sample Encoder

This block watches the raw output of an infrared receiver and turns it into a byte stream that a small firmware loop can decode. A divider produces one sample strobe every 16 × divisor clock cycles. Runs of equal level are counted in samples. A run is closed when the level changes, or when its count reaches the 7-bit limit. At that point one byte goes into a 16-entry receive FIFO. Bit 7 of the byte tells light from darkness, and bits 6:0 give the run length.

Firmware reads the bytes through an 8-register interface. An interrupt line can be raised when the FIFO holds at least half its depth, or when a byte was lost because the FIFO was full. Firmware can flush the FIFO and can put the receiver into a stopped state, in which sampling is suspended and any partial run is abandoned. An inversion bit adapts the block to receivers whose output is active-low or active-high.

Register map (3-bit address): 0 = receive data (read pops), 1 = interrupt enable, 2 = event flags (read) / FIFO control (write), 3 = divisor low byte, 4 = divisor high byte, 5 = line status, 6 = receiver control, 7 = input configuration.

Top module: `ir_rle_rx`

## Requirements
- R1: A sample strobe occurs every 16 × divisor clock cycles. A divisor of 0 stops sampling. A write to either divisor byte (address 3 or 4) restarts the phase, so the first sample after the write falls 16 × divisor cycles later.
- R2: The divisor low byte (address 3) and high byte (address 4) read back the values last written. Both are 0 after reset.
- R3: Each FIFO byte has bit 7 = 1 for a run of darkness (effective level 0) and bit 7 = 0 for a run of light (effective level 1). Bits 6:0 hold the run length in samples, from 1 to 127.
- R4: The first sample taken with a level different from the current run closes that run and pushes its byte. The new run then starts at a count of 1. An unfinished run is never pushed.
- R5: The sample that brings a run's count to 127 pushes that byte at once. The next sample starts a fresh run, even if the level has not changed.
- R6: Bit 0 of the configuration register (address 7) inverts the input before encoding. When the bit is set, a raw input of 1 is treated as darkness.
- R7: Event bit 0 (address 2) is 1 whenever the FIFO holds 8 or more bytes. The interrupt output is the OR, over bits 0 and 2, of the event bits ANDed with the enable register (address 1). The enable register keeps only bits 0 and 2, so a value of 0 turns the interrupt off.
- R8: A push into a full FIFO is dropped, the stored bytes are unchanged, and event bit 2 is set. That bit stays set until the event register is read.
- R9: Writing the receiver control register (address 6) with bit 5 set stops the receiver. No samples are taken and the partial run is discarded. Writing it with bit 5 clear restarts the receiver. Bit 5 reads back the stopped state.
- R10: A write to address 2 with bit 1 set empties the FIFO at that clock edge.
- R11: Line status bit 0 (address 5) is 1 when the FIFO is not empty. A read of address 0 returns the oldest byte and removes it. A read of an empty FIFO returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw infrared receiver level |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe, acts at the clock edge |
| reg_rd | input | 1 | Register read strobe; pop and clear effects act at the clock edge |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples it within the same cycle it drives the address. The pop or event clear that goes with a read lands at the next edge. A byte enters the FIFO at the sample edge that ends its run. Sample edges fall exactly every 16 × divisor cycles after the last divisor write, so the bench drives each run level for a whole number of sample periods from a negative edge. Any such window therefore holds exactly that many samples, whatever the phase. Status and interrupt checks are taken only after the window containing the relevant sample edge has closed. When a check has to fall in the middle of a stream, it runs in parallel with a long run, so the bus traffic does not shift the sample count.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
  localparam int BYTE_W = 8;
  localparam int RUN_W  = 7;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_IEN   = 3'd1;
  localparam logic [2:0] A_EVT   = 3'd2;
  localparam logic [2:0] A_DIVL  = 3'd3;
  localparam logic [2:0] A_DIVH  = 3'd4;
  localparam logic [2:0] A_LSTAT = 3'd5;
  localparam logic [2:0] A_CTRL  = 3'd6;
  localparam logic [2:0] A_CFG   = 3'd7;

  localparam int EVT_RX_BIT  = 0;
  localparam int EVT_ERR_BIT = 2;
  localparam int STOP_BIT    = 5;
  localparam int FLUSH_BIT   = 1;
  localparam logic [7:0] IEN_MASK = 8'h05;

  // light (1) -> flag 0, darkness (0) -> flag 1
  function automatic logic [BYTE_W-1:0] run_code(input logic lvl, input logic [RUN_W-1:0] len);
    return {~lvl, len};
  endfunction

  function automatic logic [BYTE_W-1:0] evt_code(input logic rx_level, input logic err);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[EVT_RX_BIT]  = rx_level;
    v[EVT_ERR_BIT] = err;
    return v;
  endfunction
endpackage

// File: rtl/ir_sample_tick.sv
module ir_sample_tick #(
  parameter int DIV_W    = 16,
  parameter int OVS_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  localparam int CNT_W = DIV_W + OVS_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             run_en;

  assign run_en = (div != '0);
  assign last   = {div, {OVS_LOG2{1'b0}}} - CNT_W'(1);
  assign tick   = run_en && !restart && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart || !run_en || tick) cnt <= '0;
    else                              cnt <= cnt + CNT_W'(1);
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R1
  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run_en |-> !tick); // R1
endmodule

// File: rtl/ir_run_packer.sv
module ir_run_packer
  import ir_rle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              level,
  output logic              push,
  output logic [BYTE_W-1:0] code
);
  localparam logic [RUN_W-1:0] LEN_MAX = '1;
  localparam logic [RUN_W-1:0] LEN_ONE = RUN_W'(1);

  logic             cur;
  logic [RUN_W-1:0] len;
  logic             sample;
  logic             change;
  logic             full_run;

  assign sample   = tick && enable;
  assign change   = sample && (len != '0) && (level != cur);
  assign full_run = sample && (len != '0) && (level == cur) && (len == LEN_MAX - LEN_ONE);
  assign push     = change || full_run;
  assign code     = run_code(cur, full_run ? LEN_MAX : len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= 1'b0;
      len <= '0;
    end else if (!enable) begin
      len <= '0;
    end else if (tick) begin
      if (full_run) begin
        len <= '0;
      end else if (len == '0 || change) begin
        cur <= level;
        len <= LEN_ONE;
      end else begin
        len <= len + LEN_ONE;
      end
    end
  end

  AST_PUSH_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) push |-> tick); // R4
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) push |-> (code[RUN_W-1:0] != '0)); // R3
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  input  logic                       flush,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       drop
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_ONE  = AW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign drop    = push && full && !flush;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= wp + PTR_ONE;
      if (do_pop)  rp <= rp + PTR_ONE;
      case ({do_push, do_pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= FULL_CNT); // R8
  AST_FULL_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (push && full && !pop && !flush) |=> count == $past(count)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty); // R10
endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx
  import ir_rle_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int THRESH   = 8,
  parameter int OVS_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_in,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] THR_CNT = CW'(THRESH);

  logic [7:0]        ien;
  logic [15:0]       div_q;
  logic              stopped, inv, err_flag;
  logic              tick, push, fifo_empty, fifo_drop;
  logic [BYTE_W-1:0] push_code, fifo_dout, evt;
  logic [CW-1:0]     fifo_cnt;
  logic              div_wr, flush, pop, evt_rd, at_thresh;

  assign div_wr    = reg_wr && (reg_addr == A_DIVL || reg_addr == A_DIVH);
  assign flush     = reg_wr && (reg_addr == A_EVT) && reg_wdata[FLUSH_BIT];
  assign pop       = reg_rd && (reg_addr == A_DATA);
  assign evt_rd    = reg_rd && (reg_addr == A_EVT);
  assign at_thresh = (fifo_cnt >= THR_CNT);
  assign evt       = evt_code(at_thresh, err_flag);
  assign irq       = |(evt & ien);

  ir_sample_tick #(.DIV_W(16), .OVS_LOG2(OVS_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_q), .restart(div_wr), .tick(tick)
  );

  ir_run_packer u_pack (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(!stopped),
    .level(ir_in ^ inv), .push(push), .code(push_code)
  );

  ir_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_code), .pop(pop),
    .flush(flush), .dout(fifo_dout), .count(fifo_cnt), .empty(fifo_empty),
    .drop(fifo_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien      <= '0;
      div_q    <= '0;
      stopped  <= 1'b0;
      inv      <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_IEN)  ien         <= reg_wdata & IEN_MASK;
      if (reg_wr && reg_addr == A_DIVL) div_q[7:0]  <= reg_wdata;
      if (reg_wr && reg_addr == A_DIVH) div_q[15:8] <= reg_wdata;
      if (reg_wr && reg_addr == A_CTRL) stopped     <= reg_wdata[STOP_BIT];
      if (reg_wr && reg_addr == A_CFG)  inv         <= reg_wdata[0];
      if (fifo_drop)   err_flag <= 1'b1;
      else if (evt_rd) err_flag <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = fifo_dout;
      A_IEN:   reg_rdata = ien;
      A_EVT:   reg_rdata = evt;
      A_DIVL:  reg_rdata = div_q[7:0];
      A_DIVH:  reg_rdata = div_q[15:8];
      A_LSTAT: reg_rdata = {7'b0, !fifo_empty};
      A_CTRL:  reg_rdata = {2'b0, stopped, 5'b0};
      A_CFG:   reg_rdata = {7'b0, inv};
      default: reg_rdata = '0;
    endcase
  end

  AST_STOPPED_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) stopped |-> !push); // R9
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (evt_rd && !fifo_drop) |=> !err_flag); // R8
  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n) fifo_drop |=> err_flag); // R8
endmodule

// File: tb/ir_rle_rx_test.sv
module ir_rle_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int FIFO_CAP   = 16;
  localparam logic [2:0] R_DATA = 3'd0, R_IEN = 3'd1, R_EVT = 3'd2, R_DIVL = 3'd3,
                         R_DIVH = 3'd4, R_LST = 3'd5, R_CTRL = 3'd6, R_CFG = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq;

  int n_checks = 0, n_fail = 0, period = 16;
  bit m_inv = 0, m_lvl = 0;
  int m_len = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_rle_rx uut (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1; #2; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] b);
    if (exp_q.size() < FIFO_CAP) exp_q.push_back(b);
  endtask

  // driver: one run of an effective level for n samples, predicting bytes
  task automatic drive_run(input bit lvl, input int n);
    int total;
    if (m_len != 0 && lvl != m_lvl) begin
      expect_byte({~m_lvl, 7'(m_len)});
      m_len = 0;
    end
    m_lvl = lvl;
    total = m_len + n;
    while (total >= 127) begin
      expect_byte({~lvl, 7'd127});
      total -= 127;
    end
    m_len = total;
    ir_in = lvl ^ m_inv;
    repeat (n * period) @(negedge clk);
  endtask

  task automatic restart_at(input logic [15:0] div, input bit lvl);
    ir_in = lvl ^ m_inv;
    m_len = 0;
    period = 16 * int'(div);
    bus_wr(R_DIVH, div[15:8]);
    bus_wr(R_DIVL, div[7:0]);
    bus_wr(R_CTRL, 8'h00);
  endtask

  task automatic begin_capture(input logic [15:0] div, input bit inv, input bit lvl);
    logic [7:0] d;
    bus_wr(R_CTRL, 8'h20);
    bus_wr(R_EVT, 8'h02);
    bus_rd(R_EVT, d);
    bus_wr(R_CFG, {7'b0, inv});
    m_inv = inv;
    exp_q.delete();
    restart_at(div, lvl);
  endtask

  // monitor: pop every byte the design holds and compare against the queue
  task automatic drain(input string req);
    logic [7:0] st, d, e;
    bus_rd(R_LST, st);
    while (st[0]) begin
      bus_rd(R_DATA, d);
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
      chk(req, d, e);
      bus_rd(R_LST, st);
    end
    chk({req, " leftover"}, 8'(exp_q.size()), 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state, R2 / R7 / R11
    bus_rd(R_IEN, d);  chk("R7 reset enable", d, 8'h00);
    bus_rd(R_EVT, d);  chk("R7 reset events", d, 8'h00);
    bus_rd(R_LST, d);  chk("R11 reset status", d, 8'h00);
    bus_rd(R_DIVL, d); chk("R2 reset divisor", d, 8'h00);
    bus_rd(R_CTRL, d); chk("R9 reset running", d, 8'h00);
    chk("R7 reset irq", {7'b0, irq}, 8'h00);

    // R1: divisor 0 takes no samples
    for (int i = 0; i < 12; i++) begin ir_in = ~ir_in; repeat (40) @(negedge clk); end
    bus_rd(R_LST, d); chk("R1 divisor zero idle", d, 8'h00);

    // R2: divisor readback
    bus_wr(R_DIVH, 8'h5A); bus_rd(R_DIVH, d); chk("R2 high byte", d, 8'h5A);
    bus_wr(R_DIVL, 8'hC3); bus_rd(R_DIVL, d); chk("R2 low byte", d, 8'hC3);

    // R3 R4: mixed runs
    begin_capture(16'd1, 1'b0, 1'b1);
    drive_run(1, 5); drive_run(0, 3); drive_run(1, 10); drive_run(0, 1);
    drain("R3 R4 mixed runs");

    // R5: long darkness splits at 127
    begin_capture(16'd1, 1'b0, 1'b0);
    drive_run(0, 130); drive_run(1, 1);
    drain("R5 split at 127");

    // R6: inverted input
    begin_capture(16'd1, 1'b1, 1'b0);
    drive_run(0, 4); drive_run(1, 2); drive_run(0, 1);
    drain("R6 invert");

    // R1: divisor 3 gives 48-cycle samples
    begin_capture(16'd3, 1'b0, 1'b1);
    drive_run(1, 2); drive_run(0, 3); drive_run(1, 1);
    drain("R1 divisor three");

    // R7: threshold and interrupt
    begin_capture(16'd1, 1'b0, 1'b1);
    bus_wr(R_IEN, 8'hFF);
    bus_rd(R_IEN, d); chk("R7 enable mask", d, 8'h05);
    for (int i = 0; i < 7; i++) drive_run(bit'(~i[0]), 1);
    fork
      drive_run(1'b0, 4);
      begin
        repeat (period + 2) @(negedge clk);
        bus_rd(R_EVT, d); chk("R7 seven below level", d, 8'h00);
        chk("R7 irq low at seven", {7'b0, irq}, 8'h00);
      end
    join
    drive_run(1, 1);
    bus_rd(R_EVT, d); chk("R7 eight at level", d, 8'h01);
    chk("R7 irq at eight", {7'b0, irq}, 8'h01);
    bus_wr(R_IEN, 8'h00);
    chk("R7 irq masked", {7'b0, irq}, 8'h00);
    drain("R7 stream");

    // R8: overflow
    begin_capture(16'd1, 1'b0, 1'b1);
    bus_wr(R_IEN, 8'h04);
    for (int i = 0; i < 18; i++) drive_run(bit'(~i[0]), 1);
    chk("R8 irq on overflow", {7'b0, irq}, 8'h01);
    bus_rd(R_EVT, d); chk("R8 error flag", d, 8'h05);
    bus_rd(R_EVT, d); chk("R8 flag cleared by read", d, 8'h01);
    chk("R8 irq after clear", {7'b0, irq}, 8'h00);
    bus_wr(R_IEN, 8'h00);
    drain("R8 kept bytes");

    // R9: stop discards the partial run and ignores the input
    begin_capture(16'd1, 1'b0, 1'b1);
    drive_run(1, 5);
    bus_wr(R_CTRL, 8'h20);
    bus_rd(R_CTRL, d); chk("R9 stopped readback", d, 8'h20);
    for (int i = 0; i < 10; i++) begin ir_in = ~ir_in; repeat (40) @(negedge clk); end
    bus_rd(R_LST, d); chk("R9 nothing captured", d, 8'h00);
    restart_at(16'd1, 1'b0);
    drive_run(0, 3); drive_run(1, 2);
    drain("R9 partial discarded");

    // R10 R11: flush and empty read
    begin_capture(16'd1, 1'b0, 1'b1);
    drive_run(1, 1); drive_run(0, 1); drive_run(1, 1); drive_run(0, 1);
    bus_rd(R_LST, d); chk("R11 data ready", d, 8'h01);
    bus_wr(R_EVT, 8'h02);
    exp_q.delete();
    bus_rd(R_LST, d); chk("R10 flushed", d, 8'h00);
    bus_wr(R_CTRL, 8'h20);
    bus_rd(R_DATA, d); chk("R11 empty read", d, 8'h00);
    bus_rd(R_LST, d); chk("R11 still empty", d, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule